// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block follows the operating mode of a synchronous DRAM device as its clock-enable input and command bus evolve. One CKE low level can mean three different things. With the device idle it means power-down, or self-refresh when a self-refresh command arrives on the same edge. With a bank open or a burst running it means clock suspend. Each of these modes has its own rules for accepting commands and for internal refresh.

The tracker is meant to sit beside a memory controller in a testbench or a checking environment, acting as a synthesizable device-side model. It reports the current mode and whether a command would be accepted. It raises a freeze output while internal state is held, and enables the internal refresh timer only during self-refresh. It also flags any command that the device could not legally take in its current state. An internal counter tracks the position of a read or write burst, and that position stays frozen through a clock suspend.

Top module: `sdram_cke_tracker`

## Requirements
- R1: After a clock edge with `rst_n` low, mode is IDLE (0), `cmd_accept` is 1, and `freeze`, `refresh_en`, `proto_err` and `burst_left` are all 0.
- R2: In IDLE, an edge that samples CKE low without a self-refresh command moves mode to POWER-DOWN (3). Mode stays there while CKE is sampled low. During that time `refresh_en` and `cmd_accept` are 0.
- R3: In POWER-DOWN or SELF-REFRESH, the first edge that samples CKE high returns mode to IDLE. Any command on that exit edge is not taken, and commands are accepted from the next edge.
- R4: In IDLE, an edge that samples CKE low together with the self-refresh command (7) moves mode to SELF-REFRESH (5). Mode stays there while CKE is low, with `refresh_en` at 1.
- R5: In ACTIVE (1) or READ/WRITE (2), an edge that samples CKE low moves mode to CLOCK-SUSPEND (4). While suspended, `freeze` is 1 and `cmd_accept` is 0.
- R6: During clock suspend, `bank_open` and commands have no effect on mode or burst position. The exit edge (CKE high) restores the mode that held at entry. `burst_left` is unchanged on the entry edge, on every suspended edge and on the exit edge.
- R7: In a running mode, an edge with CKE high sets mode to READ/WRITE when a burst is in progress. Otherwise it sets ACTIVE when `bank_open` is 1 and IDLE when it is 0.
- R8: A taken read (3) or write (4) loads `burst_left` with BURST_LEN. Each later edge with CKE high in a running mode decrements it until it reaches 0, and mode is READ/WRITE exactly while it is nonzero.
- R9: A command other than NOP (0) or deselect (1) that is not taken raises `proto_err` for one cycle after that edge. A command is not taken when it arrives in a low-power mode or on an edge with CKE low, unless it is the self-refresh entry from IDLE.
- R10: `proto_err` is also raised after a taken auto-refresh (6) outside IDLE, after a taken read or write in IDLE, and after a self-refresh command with CKE high. Command codes: ACT 2, PRECHARGE 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; CKE and commands are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level |
| cmd | input | 3 | Decoded command code (see R9, R10) |
| bank_open | input | 1 | High while at least one bank is active |
| mode | output | 3 | Current mode: 0 idle, 1 active, 2 read/write, 3 power-down, 4 clock suspend, 5 self-refresh |
| cmd_accept | output | 1 | High when the next edge may take a command |
| freeze | output | 1 | High while internal state is held in clock suspend |
| refresh_en | output | 1 | Internal refresh-timer enable, high only in self-refresh |
| proto_err | output | 1 | Command protocol violation seen on the previous edge |
| burst_left | output | BW | Beats remaining in the current burst |

## Verification
On every cycle the embedded assertions check the mode transitions: power-down hold, exits to idle, self-refresh entry, suspend entry, and the return to the saved mode. They also check that the burst counter stays still whenever it is not enabled, and that a command arriving in a low-power mode is always flagged. Only the bench's scenarios can show the complete picture. The bench sweeps every reachable starting mode against every CKE level, command and bank status. It counts a burst down through a long suspend in which the bank status and commands change. It also checks that the exit edge ignores its command while the following edge accepts one.

// File: rtl/cke_trk_pkg.sv
// Shared types for the CKE power-state tracker.
// Assumes a 3-bit command code already decoded from the pin-level bus.
package cke_trk_pkg;

    typedef enum logic [2:0] {
        M_IDLE    = 3'd0,
        M_ACTIVE  = 3'd1,
        M_RW      = 3'd2,
        M_PDOWN   = 3'd3,
        M_SUSPEND = 3'd4,
        M_SELFREF = 3'd5
    } mode_e;

    typedef enum logic [2:0] {
        C_NOP   = 3'd0,
        C_DESEL = 3'd1,
        C_ACT   = 3'd2,
        C_READ  = 3'd3,
        C_WRITE = 3'd4,
        C_PRE   = 3'd5,
        C_AREF  = 3'd6,
        C_SREF  = 3'd7
    } cmd_e;

    // True for the modes in which the device takes commands.
    function automatic logic is_running(mode_e m);
        return (m == M_IDLE) || (m == M_ACTIVE) || (m == M_RW);
    endfunction

    // True for any command that asks the device to do something.
    function automatic logic is_real(cmd_e c);
        return (c != C_NOP) && (c != C_DESEL);
    endfunction

endpackage

// File: rtl/cke_cmd_guard.sv
// Command qualifier: decides, per edge, whether the command is taken,
// whether it starts a burst or enters self-refresh, and flags illegal use.
// Assumes mode_q is the tracker's registered mode for the current cycle.
module cke_cmd_guard
    import cke_trk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cke,
    input  cmd_e  cmd,
    input  mode_e mode_q,
    output logic  taken,
    output logic  burst_load,
    output logic  sref_entry,
    output logic  adv_en,
    output logic  proto_err
);
    logic run;
    logic real_cmd;
    logic bad_state;
    logic viol;
    logic err_q;

    // Classify the command arriving on this edge.
    always_comb begin
        run        = is_running(mode_q);
        real_cmd   = is_real(cmd);
        sref_entry = (mode_q == M_IDLE) && !cke && (cmd == C_SREF);
        taken      = run && cke && real_cmd && (cmd != C_SREF);
        burst_load = taken && ((cmd == C_READ) || (cmd == C_WRITE));
        adv_en     = run && cke;
        bad_state  = taken && (((cmd == C_AREF) && (mode_q != M_IDLE)) ||
                               (((cmd == C_READ) || (cmd == C_WRITE)) && (mode_q == M_IDLE)));
        viol       = (real_cmd && !taken && !sref_entry) || bad_state;
    end

    // Register the violation flag for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= viol;
    end

    assign proto_err = err_q;

    // R9: a real command while commands are disabled is always flagged.
    assert_lowpower_cmd_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_running(mode_q) && (cmd != C_NOP) && (cmd != C_DESEL)) |=> proto_err);

    // R10: a self-refresh command with CKE high is flagged.
    assert_sref_cke_high_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && (cmd == C_SREF)) |=> proto_err);

endmodule

// File: rtl/cke_burst_ctr.sv
// Burst position counter: loads the burst length on a taken read or write
// and counts down on each enabled edge; holds while not enabled.
// Assumes load is only raised on an enabled edge.
module cke_burst_ctr #(
    parameter int BURST_LEN = 4,
    localparam int BW = $clog2(BURST_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    output logic [BW-1:0] cnt_d,
    output logic [BW-1:0] cnt_q
);
    localparam logic [BW-1:0] LOAD_VAL = BW'(BURST_LEN);

    // Next-count selection: hold, reload or step down.
    always_comb begin
        cnt_d = cnt_q;
        if (en) begin
            if (load)              cnt_d = LOAD_VAL;
            else if (cnt_q != '0)  cnt_d = cnt_q - BW'(1);
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: without an enable the burst position is frozen.
    assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));

    // R8: a taken read or write starts a full burst.
    assert_burst_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/cke_mode_fsm.sv
// Mode state machine: follows idle, active, read/write, power-down,
// clock suspend and self-refresh from the sampled CKE level.
// Assumes sref_entry and burst_nz_d come from the same edge's qualifier.
module cke_mode_fsm
    import cke_trk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cke,
    input  logic  sref_entry,
    input  logic  bank_open,
    input  logic  burst_nz_d,
    output mode_e mode_q
);
    mode_e mode_d;
    mode_e resume_q;
    mode_e resume_d;

    // Next-mode decision from the mode in which CKE is sampled.
    always_comb begin
        mode_d   = mode_q;
        resume_d = resume_q;
        case (mode_q)
            M_IDLE, M_ACTIVE, M_RW: begin
                if (cke) begin
                    if (burst_nz_d)     mode_d = M_RW;
                    else if (bank_open) mode_d = M_ACTIVE;
                    else                mode_d = M_IDLE;
                end else if (mode_q == M_IDLE) begin
                    mode_d = sref_entry ? M_SELFREF : M_PDOWN;
                end else begin
                    mode_d   = M_SUSPEND;
                    resume_d = mode_q;
                end
            end
            M_PDOWN, M_SELFREF: begin
                if (cke) mode_d = M_IDLE;
            end
            M_SUSPEND: begin
                if (cke) mode_d = resume_q;
            end
            default: mode_d = M_IDLE;
        endcase
    end

    // Mode and saved pre-suspend mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= M_IDLE;
            resume_q <= M_ACTIVE;
        end else begin
            mode_q   <= mode_d;
            resume_q <= resume_d;
        end
    end

    // R2: power-down holds while CKE stays low.
    assert_pdown_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_PDOWN) && !cke) |=> (mode_q == M_PDOWN));

    // R3: a high CKE leaves power-down or self-refresh for idle.
    assert_lowpower_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode_q == M_PDOWN) || (mode_q == M_SELFREF)) && cke) |=> (mode_q == M_IDLE));

    // R4: self-refresh command with CKE low in idle enters self-refresh.
    assert_sref_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_IDLE) && !cke && sref_entry) |=> (mode_q == M_SELFREF));

    // R5: CKE low with a bank open or a burst running enters clock suspend.
    assert_suspend_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((mode_q == M_ACTIVE) || (mode_q == M_RW)) && !cke) |=> (mode_q == M_SUSPEND));

    // R6: suspend exit restores the mode saved at entry.
    assert_suspend_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_SUSPEND) && cke) |=> (mode_q == $past(resume_q)));

endmodule

// File: rtl/sdram_cke_tracker.sv
// Top of the CKE power-state tracker: joins the command qualifier, burst
// counter and mode machine and drives the status outputs.
// Assumes cke, cmd and bank_open are synchronous to clk.
module sdram_cke_tracker
    import cke_trk_pkg::*;
#(
    parameter int BURST_LEN = 4,
    localparam int BW = $clog2(BURST_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke,
    input  logic [2:0]    cmd,
    input  logic          bank_open,
    output logic [2:0]    mode,
    output logic          cmd_accept,
    output logic          freeze,
    output logic          refresh_en,
    output logic          proto_err,
    output logic [BW-1:0] burst_left
);
    mode_e         mode_q;
    cmd_e          cmd_c;
    logic          taken;
    logic          burst_load;
    logic          sref_entry;
    logic          adv_en;
    logic [BW-1:0] cnt_d;
    logic [BW-1:0] cnt_q;

    assign cmd_c = cmd_e'(cmd);

    cke_cmd_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cmd        (cmd_c),
        .mode_q     (mode_q),
        .taken      (taken),
        .burst_load (burst_load),
        .sref_entry (sref_entry),
        .adv_en     (adv_en),
        .proto_err  (proto_err)
    );

    cke_burst_ctr #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv_en),
        .load  (burst_load),
        .cnt_d (cnt_d),
        .cnt_q (cnt_q)
    );

    cke_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .sref_entry (sref_entry),
        .bank_open  (bank_open),
        .burst_nz_d (cnt_d != '0),
        .mode_q     (mode_q)
    );

    // Status outputs decoded from the registered mode.
    always_comb begin
        mode       = mode_q;
        cmd_accept = is_running(mode_q);
        freeze     = (mode_q == M_SUSPEND);
        refresh_en = (mode_q == M_SELFREF);
        burst_left = cnt_q;
    end

    // R2: no internal refresh in power-down, and no command accepted.
    assert_pdown_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_IDLE) && !cke && !sref_entry) |=> (!refresh_en && !cmd_accept));

    // R8: a taken burst command shows up as read/write mode.
    assert_burst_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_load && taken) |=> (mode == 3'd2));

endmodule

// File: tb/sdram_cke_tracker_test.sv
module sdram_cke_tracker_test;
    localparam int CLK_P = 10;
    localparam int BL    = 4;
    localparam int BW    = $clog2(BL + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cke;
    logic [2:0]    cmd;
    logic          bank_open;
    logic [2:0]    mode;
    logic          cmd_accept;
    logic          freeze;
    logic          refresh_en;
    logic          proto_err;
    logic [BW-1:0] burst_left;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sdram_cke_tracker #(.BURST_LEN(BL)) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank_open(bank_open),
        .mode(mode), .cmd_accept(cmd_accept), .freeze(freeze),
        .refresh_en(refresh_en), .proto_err(proto_err), .burst_left(burst_left)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cke = 1'b1; cmd = 3'd0; bank_open = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    // Bring the design to a start mode: 0 idle,1 active,2 rw,3 pd,4 suspend,5 sref
    task automatic go_to(input int s);
        do_reset();
        case (s)
            1: begin bank_open = 1; cmd = 3'd2; step(); cmd = 3'd0; end
            2: begin bank_open = 1; cmd = 3'd2; step(); cmd = 3'd3; step(); cmd = 3'd0; end
            3: begin cke = 0; step(); end
            4: begin bank_open = 1; cmd = 3'd2; step(); cmd = 3'd3; step(); cmd = 3'd0;
                     cke = 0; step(); end
            5: begin cke = 0; cmd = 3'd7; step(); cmd = 3'd0; end
            default: ;
        endcase
    endtask

    // Expected result of one edge from the requirements.
    task automatic predict(input int m, input int bq, input int r, input bit c, input int k,
                           input bit b, output int md, output int err, output int bd);
        bit run, rl, se, tk, ld, bad;
        run = (m <= 2);
        rl  = (k >= 2);
        se  = (m == 0) && !c && (k == 7);
        tk  = run && c && rl && (k != 7);
        ld  = tk && (k == 3 || k == 4);
        bad = (tk && k == 6 && m != 0) || (ld && m == 0);
        err = ((rl && !tk && !se) || bad) ? 1 : 0;
        if (!(run && c))   bd = bq;
        else if (ld)       bd = BL;
        else               bd = (bq > 0) ? bq - 1 : 0;
        if (run) begin
            if (c)           md = (bd != 0) ? 2 : (b ? 1 : 0);
            else if (m == 0) md = (k == 7) ? 5 : 3;
            else             md = 4;
        end else if (m == 4) md = c ? r : 4;
        else                 md = c ? 0 : m;
    endtask

    initial begin
        string tag;
        int md, er, bd;
        do_reset();
        // R1 reset state
        chk("R1", "mode", mode, 0);
        chk("R1", "cmd_accept", cmd_accept, 1);
        chk("R1", "freeze", freeze, 0);
        chk("R1", "refresh_en", refresh_en, 0);
        chk("R1", "proto_err", proto_err, 0);
        chk("R1", "burst_left", burst_left, 0);

        // R2 power-down held over several cycles
        go_to(3);
        for (int i = 0; i < 5; i++) begin
            chk("R2", "mode", mode, 3);
            chk("R2", "refresh_en", refresh_en, 0);
            chk("R2", "cmd_accept", cmd_accept, 0);
            step();
        end
        // R3 exit edge ignores its command, next edge accepts
        cke = 1; cmd = 3'd2; bank_open = 1; step();
        chk("R3", "mode", mode, 0);
        chk("R3", "cmd_accept", cmd_accept, 1);
        chk("R3", "proto_err", proto_err, 1);
        step();
        chk("R3", "mode after accept", mode, 1);
        chk("R3", "proto_err after accept", proto_err, 0);
        cmd = 3'd0;

        // R4 self-refresh held, refresh timer enabled
        go_to(5);
        for (int i = 0; i < 4; i++) begin
            chk("R4", "mode", mode, 5);
            chk("R4", "refresh_en", refresh_en, 1);
            step();
        end

        // R8 full burst countdown then back to active
        go_to(1);
        cmd = 3'd4; step(); cmd = 3'd0;
        for (int i = BL; i >= 0; i--) begin
            chk("R8", "burst_left", burst_left, i);
            chk("R8", "mode", mode, (i != 0) ? 2 : 1);
            step();
        end

        // R5 R6 long suspend with changing bank status and commands
        go_to(2);
        step();
        chk("R8", "burst after one beat", burst_left, BL - 1);
        cke = 0; step();
        chk("R5", "mode", mode, 4);
        chk("R5", "freeze", freeze, 1);
        chk("R5", "cmd_accept", cmd_accept, 0);
        for (int i = 0; i < 3; i++) begin
            bank_open = i[0]; cmd = 3'd4; step();
            chk("R6", "burst held", burst_left, BL - 1);
            chk("R6", "mode held", mode, 4);
            chk("R9", "ignored cmd flagged", proto_err, 1);
        end
        cmd = 3'd0; bank_open = 0; cke = 1; step();
        chk("R6", "resume mode", mode, 2);
        chk("R6", "burst on exit", burst_left, BL - 1);
        step();
        chk("R6", "burst resumes", burst_left, BL - 2);

        // R10 illegal commands in running modes
        go_to(0);
        cmd = 3'd3; step(); cmd = 3'd0;
        chk("R10", "read in idle", proto_err, 1);
        go_to(1);
        cmd = 3'd6; step(); cmd = 3'd0;
        chk("R10", "aref with open bank", proto_err, 1);
        go_to(0);
        cmd = 3'd7; step(); cmd = 3'd0;
        chk("R10", "sref with cke high", proto_err, 1);
        chk("R10", "sref cke high mode", mode, 0);

        // Sweep: every start mode x CKE x command x bank status (R2..R10)
        for (int s = 0; s < 6; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 8; k++) begin
                    for (int b = 0; b < 2; b++) begin
                        int bq;
                        bq = (s == 2 || s == 4) ? BL : 0;
                        go_to(s);
                        cke = c[0]; cmd = k[2:0]; bank_open = b[0];
                        step();
                        predict(s, bq, 2, c[0], k, b[0], md, er, bd);
                        case (s)
                            0: tag = "R7";
                            1: tag = "R5";
                            2: tag = "R8";
                            3: tag = "R2";
                            4: tag = "R6";
                            default: tag = "R4";
                        endcase
                        chk(tag, "sweep mode", mode, md);
                        chk(tag, "sweep cmd_accept", cmd_accept, (md <= 2) ? 1 : 0);
                        chk(tag, "sweep freeze", freeze, (md == 4) ? 1 : 0);
                        chk(tag, "sweep refresh_en", refresh_en, (md == 5) ? 1 : 0);
                        chk("R9", "sweep proto_err", proto_err, er);
                        chk("R8", "sweep burst_left", burst_left, bd);
                    end
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule